// File: doc/BRIEF.md
# Output Driver Calibration Controller

This block is the device-side control for output driver strength calibration in a memory die. When the extended mode register that holds the calibration field is written, the block decodes a 3-bit calibration command. Each command takes the block out of its idle state and must be closed by an exit command.

Two of the commands force the data and strobe pads to fixed levels. The override turns on a fixed number of cycles after the command and turns off the same number of cycles after the exit. The adjust command waits the write latency, then reads a 4-beat code from one data line, one beat per cycle. That code raises or lowers two independent saturating strength counters, one for pull-up and one for pull-down. The default command reloads both counters to a mid-range value.

State machine:
- IDLE waits for a command.
- DRV_ON waits out the turn-on delay, then DRIVE holds the forced levels.
- After an exit, DRV_OFF waits out the turn-off delay and then returns to IDLE.
- ADJ_WAIT counts down the write latency.
- ADJ_BEAT gathers the remaining beats.
- HOLD waits for the exit after an adjust has been applied or after a default load.

Transitions:
- An exit leaves DRV_ON, ADJ_WAIT, ADJ_BEAT and HOLD directly to IDLE.
- DRIVE goes to DRV_OFF on an exit.
- ADJ_WAIT moves to ADJ_BEAT when its count reaches zero.
- ADJ_BEAT moves to HOLD on the fourth beat.

Top module: `ocd_adjust_ctrl`

## Requirements
- R1: After reset both strength counters hold DFLT_STEP (8 by default), and drv_en, all drive levels, cal_mode and seq_err are 0.
- R2: The 3-bit command on ocd_code, taken when emr_wr is high, is decoded as follows: 000 exit, 001 drive high, 010 drive low, 100 adjust, 111 default. cal_mode is 1 from the cycle after any non-exit command until the block is back in IDLE.
- R3: While drv_en is 1, the drive-high command gives dq_drv=1, dqs_drv=1, dqsn_drv=0, and the drive-low command gives the inverse. While drv_en is 0, all three levels are 0.
- R4: Take a drive command at clock edge t. drv_en is first 1 after edge t+TOIT. Take an exit at edge u while driving. drv_en is first 0 after edge u+TOIT, and cal_mode falls at the same time.
- R5: Take an adjust command at edge t with write latency WL (a value of 0 acts as 1). dq_bit is sampled as DT0 at edge t+WL and as DT1, DT2, DT3 at the next three edges. The code is written DT0 DT1 DT2 DT3, left to right, and the counters show its effect after edge t+WL+3.
- R6: The adjust codes act as follows:
  - 0001 raises pull-up by one step.
  - 0010 lowers pull-up.
  - 0100 raises pull-down.
  - 1000 lowers pull-down.
  - 0101 raises both.
  - 0110 lowers pull-up and raises pull-down.
  - 1001 raises pull-up and lowers pull-down.
  - 1010 lowers both.
- R7: The adjust code 0000 and every adjust code not listed in R6 leave both counters unchanged.
- R8: Each counter spans 0 to STEPS-1 (0 to 15). A raise at 15 or a lower at 0 leaves the counter unchanged, and a counter never wraps.
- R9: The default command loads both counters with DFLT_STEP. The load is visible after the command's edge.
- R10: A reserved command (011, 101 or 110) in IDLE, or any non-exit command while a calibration command is outstanding, makes seq_err 1 for exactly the next cycle. Such a command changes neither the state, the counters nor the drive levels.
- R11: An exit in IDLE leaves the counters unchanged. An exit before the fourth adjust beat abandons the adjust with no counter change. Each adjust command applies at most one update, and later dq_bit activity in HOLD has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| emr_wr | input | 1 | Decoded write strobe for the register that holds the calibration field |
| ocd_code | input | 3 | Calibration command field |
| wr_lat | input | WL_W | Write latency in cycles |
| dq_bit | input | 1 | Sampled data bit, one beat per cycle |
| pu_step | output | $clog2(STEPS) | Pull-up strength step |
| pd_step | output | $clog2(STEPS) | Pull-down strength step |
| drv_en | output | 1 | Pad drive override active |
| dq_drv | output | 1 | Forced data level |
| dqs_drv | output | 1 | Forced true strobe level |
| dqsn_drv | output | 1 | Forced complementary strobe level |
| cal_mode | output | 1 | A calibration command is outstanding |
| seq_err | output | 1 | One-cycle pulse for a reserved or out-of-sequence command |

## Verification
The assertions check several properties on every cycle:
- The complementary strobe opposes the true strobe whenever the override is active, and all levels are 0 when it is not.
- The override is never active outside calibration.
- A counter moves by at most one step per cycle and never wraps.
- The counters stay still while no calibration is outstanding.
- seq_err appears only after a register write.

Only the scenarios can show the rest: the exact turn-on and turn-off delays, the beat alignment to the write latency, each code's effect, saturation, the abandoned and repeated adjusts, and the rejection of out-of-order commands.

// File: rtl/ocd_pkg.sv
package ocd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRV_ON,
        ST_DRIVE,
        ST_DRV_OFF,
        ST_ADJ_WAIT,
        ST_ADJ_BEAT,
        ST_HOLD
    } ocd_state_e;

    localparam logic [2:0] CMD_EXIT = 3'b000;
    localparam logic [2:0] CMD_DRV1 = 3'b001;
    localparam logic [2:0] CMD_DRV0 = 3'b010;
    localparam logic [2:0] CMD_ADJ  = 3'b100;
    localparam logic [2:0] CMD_DFLT = 3'b111;

    typedef struct packed {
        logic pu_up;
        logic pu_dn;
        logic pd_up;
        logic pd_dn;
    } step_req_t;

endpackage

// File: rtl/ocd_burst_decode.sv
module ocd_burst_decode
    import ocd_pkg::*;
(
    input  logic [3:0] burst_code,
    output step_req_t  req
);

    // burst_code[3] is the first beat, burst_code[0] the last
    always_comb begin
        req = '0;
        case (burst_code)
            4'b0001: req.pu_up = 1'b1;
            4'b0010: req.pu_dn = 1'b1;
            4'b0100: req.pd_up = 1'b1;
            4'b1000: req.pd_dn = 1'b1;
            4'b0101: begin req.pu_up = 1'b1; req.pd_up = 1'b1; end
            4'b0110: begin req.pu_dn = 1'b1; req.pd_up = 1'b1; end
            4'b1001: begin req.pu_up = 1'b1; req.pd_dn = 1'b1; end
            4'b1010: begin req.pu_dn = 1'b1; req.pd_dn = 1'b1; end
            default: req = '0;
        endcase
    end

endmodule

// File: rtl/ocd_step_ctr.sv
module ocd_step_ctr #(
    parameter int STEPS = 16,
    parameter int DFLT  = 8,
    localparam int SW   = $clog2(STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_dflt,
    input  logic          step_en,
    input  logic          up,
    input  logic          dn,
    output logic [SW-1:0] level
);

    localparam logic [SW-1:0] TOP  = SW'(STEPS - 1);
    localparam logic [SW-1:0] INIT = SW'(DFLT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= INIT;
        end else if (load_dflt) begin
            level <= INIT;
        end else if (step_en && up && (level != TOP)) begin
            level <= level + SW'(1);
        end else if (step_en && dn && (level != '0)) begin
            level <= level - SW'(1);
        end
    end

endmodule

// File: rtl/ocd_adjust_ctrl.sv
module ocd_adjust_ctrl
    import ocd_pkg::*;
#(
    parameter int STEPS     = 16,
    parameter int DFLT_STEP = 8,
    parameter int TOIT      = 4,
    parameter int WL_W      = 4,
    localparam int SW       = $clog2(STEPS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            emr_wr,
    input  logic [2:0]      ocd_code,
    input  logic [WL_W-1:0] wr_lat,
    input  logic            dq_bit,
    output logic [SW-1:0]   pu_step,
    output logic [SW-1:0]   pd_step,
    output logic            drv_en,
    output logic            dq_drv,
    output logic            dqs_drv,
    output logic            dqsn_drv,
    output logic            cal_mode,
    output logic            seq_err
);

    localparam int TW    = $clog2(TOIT + 1);
    localparam int CNT_W = (WL_W > TW) ? WL_W : TW;
    localparam logic [CNT_W-1:0] OIT_LOAD = CNT_W'(TOIT - 1);

    ocd_state_e      state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic [1:0]      beat, beat_n;
    logic [2:0]      shr, shr_n;
    logic            lvl, lvl_n;
    logic            err_q, err_n;
    logic            upd;
    logic            dflt_load;
    logic            is_exit, is_other;
    logic [CNT_W-1:0] wl_load;
    step_req_t       req;

    assign is_exit  = emr_wr && (ocd_code == CMD_EXIT);
    assign is_other = emr_wr && (ocd_code != CMD_EXIT);
    assign wl_load  = (wr_lat == '0) ? '0 : (CNT_W'(wr_lat) - CNT_W'(1));

    ocd_burst_decode u_dec (
        .burst_code ({shr, dq_bit}),
        .req        (req)
    );

    ocd_step_ctr #(.STEPS(STEPS), .DFLT(DFLT_STEP)) u_pu (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_dflt (dflt_load),
        .step_en   (upd),
        .up        (req.pu_up),
        .dn        (req.pu_dn),
        .level     (pu_step)
    );

    ocd_step_ctr #(.STEPS(STEPS), .DFLT(DFLT_STEP)) u_pd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_dflt (dflt_load),
        .step_en   (upd),
        .up        (req.pd_up),
        .dn        (req.pd_dn),
        .level     (pd_step)
    );

    // next-state and datapath decisions
    always_comb begin
        state_n   = state;
        cnt_n     = cnt;
        beat_n    = beat;
        shr_n     = shr;
        lvl_n     = lvl;
        err_n     = 1'b0;
        upd       = 1'b0;
        dflt_load = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (emr_wr) begin
                    case (ocd_code)
                        CMD_EXIT: ;
                        CMD_DRV1: begin
                            state_n = ST_DRV_ON;
                            lvl_n   = 1'b1;
                            cnt_n   = OIT_LOAD;
                        end
                        CMD_DRV0: begin
                            state_n = ST_DRV_ON;
                            lvl_n   = 1'b0;
                            cnt_n   = OIT_LOAD;
                        end
                        CMD_ADJ: begin
                            state_n = ST_ADJ_WAIT;
                            cnt_n   = wl_load;
                            beat_n  = 2'd0;
                            shr_n   = 3'b000;
                        end
                        CMD_DFLT: begin
                            state_n   = ST_HOLD;
                            dflt_load = 1'b1;
                        end
                        default: err_n = 1'b1;
                    endcase
                end
            end
            ST_DRV_ON: begin
                if (is_exit) begin
                    state_n = ST_IDLE;
                end else begin
                    err_n = is_other;
                    if (cnt == '0) state_n = ST_DRIVE;
                    else           cnt_n   = cnt - CNT_W'(1);
                end
            end
            ST_DRIVE: begin
                if (is_exit) begin
                    state_n = ST_DRV_OFF;
                    cnt_n   = OIT_LOAD;
                end else begin
                    err_n = is_other;
                end
            end
            ST_DRV_OFF: begin
                err_n = is_other;
                if (cnt == '0) state_n = ST_IDLE;
                else           cnt_n   = cnt - CNT_W'(1);
            end
            ST_ADJ_WAIT: begin
                if (is_exit) begin
                    state_n = ST_IDLE;
                end else begin
                    err_n = is_other;
                    if (cnt == '0) begin
                        shr_n   = {shr[1:0], dq_bit};
                        beat_n  = 2'd1;
                        state_n = ST_ADJ_BEAT;
                    end else begin
                        cnt_n = cnt - CNT_W'(1);
                    end
                end
            end
            ST_ADJ_BEAT: begin
                if (is_exit) begin
                    state_n = ST_IDLE;
                end else begin
                    err_n = is_other;
                    if (beat == 2'd3) begin
                        upd     = 1'b1;
                        state_n = ST_HOLD;
                    end else begin
                        shr_n  = {shr[1:0], dq_bit};
                        beat_n = beat + 2'd1;
                    end
                end
            end
            ST_HOLD: begin
                if (is_exit) state_n = ST_IDLE;
                else         err_n   = is_other;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            beat  <= 2'd0;
            shr   <= 3'b000;
            lvl   <= 1'b0;
            err_q <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            beat  <= beat_n;
            shr   <= shr_n;
            lvl   <= lvl_n;
            err_q <= err_n;
        end
    end

    // outputs
    always_comb begin
        drv_en   = (state == ST_DRIVE) || (state == ST_DRV_OFF);
        dq_drv   = drv_en & lvl;
        dqs_drv  = drv_en & lvl;
        dqsn_drv = drv_en & ~lvl;
        cal_mode = (state != ST_IDLE);
        seq_err  = err_q;
    end

endmodule

// File: rtl/ocd_adjust_ctrl_chk.sv
module ocd_adjust_ctrl_chk #(
    parameter int STEPS = 16,
    localparam int SW   = $clog2(STEPS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          emr_wr,
    input logic [SW-1:0] pu_step,
    input logic [SW-1:0] pd_step,
    input logic          drv_en,
    input logic          dq_drv,
    input logic          dqs_drv,
    input logic          dqsn_drv,
    input logic          cal_mode,
    input logic          seq_err
);

    localparam logic [SW-1:0] TOP = SW'(STEPS - 1);

    // R3
    strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> (dqsn_drv != dqs_drv) && (dq_drv == dqs_drv));

    // R3
    idle_levels_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> !dq_drv && !dqs_drv && !dqsn_drv);

    // R4
    drive_in_cal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> cal_mode);

    // R8
    pu_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(emr_wr) && !$stable(pu_step)) |->
        ((pu_step == $past(pu_step) + SW'(1)) || (pu_step == $past(pu_step) - SW'(1))));

    // R8
    pd_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(emr_wr) && !$stable(pd_step)) |->
        ((pd_step == $past(pd_step) + SW'(1)) || (pd_step == $past(pd_step) - SW'(1))));

    // R8
    pu_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pu_step) == TOP && !$past(emr_wr)) |-> (pu_step != '0));

    // R8
    pd_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pd_step) == '0 && !$past(emr_wr)) |-> (pd_step != TOP));

    // R11
    idle_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cal_mode) && !$past(emr_wr)) |-> ($stable(pu_step) && $stable(pd_step)));

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> $past(emr_wr));

endmodule

bind ocd_adjust_ctrl ocd_adjust_ctrl_chk #(.STEPS(STEPS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .emr_wr   (emr_wr),
    .pu_step  (pu_step),
    .pd_step  (pd_step),
    .drv_en   (drv_en),
    .dq_drv   (dq_drv),
    .dqs_drv  (dqs_drv),
    .dqsn_drv (dqsn_drv),
    .cal_mode (cal_mode),
    .seq_err  (seq_err)
);

// File: tb/ocd_adjust_ctrl_tb.sv
module ocd_adjust_ctrl_tb;

    localparam int STEPS = 16;
    localparam int DFLT  = 8;
    localparam int TOIT  = 4;
    localparam int WL_W  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            emr_wr = 1'b0;
    logic [2:0]      ocd_code = 3'b000;
    logic [WL_W-1:0] wr_lat = '0;
    logic            dq_bit = 1'b0;
    logic [3:0]      pu_step, pd_step;
    logic            drv_en, dq_drv, dqs_drv, dqsn_drv, cal_mode, seq_err;

    int n_chk = 0;
    int n_err = 0;
    int exp_pu = DFLT;
    int exp_pd = DFLT;
    bit done = 1'b0;

    ocd_adjust_ctrl #(.STEPS(STEPS), .DFLT_STEP(DFLT), .TOIT(TOIT), .WL_W(WL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .emr_wr(emr_wr), .ocd_code(ocd_code),
        .wr_lat(wr_lat), .dq_bit(dq_bit), .pu_step(pu_step), .pd_step(pd_step),
        .drv_en(drv_en), .dq_drv(dq_drv), .dqs_drv(dqs_drv), .dqsn_drv(dqsn_drv),
        .cal_mode(cal_mode), .seq_err(seq_err)
    );

    always #2 clk = ~clk;

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int clampv(int v);
        return (v < 0) ? 0 : ((v > STEPS - 1) ? STEPS - 1 : v);
    endfunction

    task automatic model(logic [3:0] c);
        int dpu = 0;
        int dpd = 0;
        case (c)
            4'b0001: dpu = 1;
            4'b0010: dpu = -1;
            4'b0100: dpd = 1;
            4'b1000: dpd = -1;
            4'b0101: begin dpu = 1;  dpd = 1;  end
            4'b0110: begin dpu = -1; dpd = 1;  end
            4'b1001: begin dpu = 1;  dpd = -1; end
            4'b1010: begin dpu = -1; dpd = -1; end
            default: ;
        endcase
        exp_pu = clampv(exp_pu + dpu);
        exp_pd = clampv(exp_pd + dpd);
    endtask

    task automatic send(logic [2:0] c);
        @(negedge clk);
        emr_wr = 1'b1;
        ocd_code = c;
        @(negedge clk);
        emr_wr = 1'b0;
        ocd_code = 3'b000;
    endtask

    task automatic beats(logic [3:0] c);
        dq_bit = c[3];
        @(negedge clk) dq_bit = c[2];
        @(negedge clk) dq_bit = c[1];
        @(negedge clk) dq_bit = c[0];
        @(negedge clk) dq_bit = 1'b0;
    endtask

    // R5 R6 R7: one adjust with a given burst code and latency
    task automatic run_adjust(logic [3:0] c, int wl, string req);
        @(negedge clk);
        emr_wr = 1'b1;
        ocd_code = 3'b100;
        wr_lat = WL_W'(wl);
        @(negedge clk);
        emr_wr = 1'b0;
        ocd_code = 3'b000;
        for (int k = 1; k < wl; k++) @(negedge clk);
        beats(c);
        model(c);
        check({req, " pull-up"}, pu_step, exp_pu);
        check({req, " pull-down"}, pd_step, exp_pd);
        check("R2 cal_mode in adjust", cal_mode, 1);
        send(3'b000);
        check("R2 cal_mode after exit", cal_mode, 0);
    endtask

    task automatic test_reset();
        check("R1 pull-up reset", pu_step, DFLT);
        check("R1 pull-down reset", pd_step, DFLT);
        check("R1 drv_en reset", drv_en, 0);
        check("R1 levels reset", {dq_drv, dqs_drv, dqsn_drv}, 0);
        check("R1 cal_mode reset", cal_mode, 0);
        check("R1 seq_err reset", seq_err, 0);
    endtask

    // R3 R4: drive mode levels and delays
    task automatic test_drive(bit lvl);
        send(lvl ? 3'b001 : 3'b010);
        for (int k = 0; k <= TOIT + 1; k++) begin
            check("R4 drive turn-on delay", drv_en, (k >= TOIT) ? 1 : 0);
            if (k >= TOIT) begin
                check("R3 dq level", dq_drv, lvl);
                check("R3 dqs level", dqs_drv, lvl);
                check("R3 dqsn level", dqsn_drv, !lvl);
            end
            @(negedge clk);
        end
        send(3'b000);
        for (int k = 0; k <= TOIT + 1; k++) begin
            check("R4 drive turn-off delay", drv_en, (k < TOIT) ? 1 : 0);
            check("R4 cal_mode falls with drive", cal_mode, (k < TOIT) ? 1 : 0);
            @(negedge clk);
        end
        check("R3 levels low when off", {dq_drv, dqs_drv, dqsn_drv}, 0);
    endtask

    task automatic test_codes();
        run_adjust(4'b0001, 1, "R6 0001");
        run_adjust(4'b0010, 3, "R6 0010");
        run_adjust(4'b0100, 5, "R6 0100");
        run_adjust(4'b1000, 2, "R6 1000");
        run_adjust(4'b0101, 4, "R6 0101");
        run_adjust(4'b0110, 1, "R6 0110");
        run_adjust(4'b1001, 3, "R6 1001");
        run_adjust(4'b1010, 2, "R6 1010");
        run_adjust(4'b0000, 2, "R7 0000");
        run_adjust(4'b0011, 3, "R7 0011");
        run_adjust(4'b1111, 1, "R7 1111");
        run_adjust(4'b0100, 0, "R5 latency zero");
    endtask

    task automatic test_saturate();
        for (int i = 0; i < 10; i++) run_adjust(4'b0001, 1, "R8 raise");
        check("R8 pull-up top", pu_step, 15);
        for (int i = 0; i < 20; i++) run_adjust(4'b1000, 1, "R8 lower");
        check("R8 pull-down bottom", pd_step, 0);
    endtask

    task automatic test_default();
        send(3'b111);
        exp_pu = DFLT;
        exp_pd = DFLT;
        check("R9 default pull-up", pu_step, DFLT);
        check("R9 default pull-down", pd_step, DFLT);
        check("R9 cal_mode", cal_mode, 1);
        send(3'b000);
        check("R9 exit", cal_mode, 0);
    endtask

    task automatic test_errors();
        send(3'b011);
        check("R10 reserved cmd err", seq_err, 1);
        check("R10 reserved cmd no mode", cal_mode, 0);
        @(negedge clk);
        check("R10 err one cycle", seq_err, 0);
        send(3'b110);
        check("R10 reserved 110 err", seq_err, 1);
        test_drive_err();
    endtask

    task automatic test_drive_err();
        send(3'b001);
        for (int k = 0; k < TOIT; k++) @(negedge clk);
        send(3'b100);
        check("R10 cmd during drive err", seq_err, 1);
        check("R10 drive kept", drv_en, 1);
        check("R10 level kept", dq_drv, 1);
        send(3'b111);
        check("R10 default rejected pu", pu_step, exp_pu);
        send(3'b000);
        for (int k = 0; k <= TOIT; k++) @(negedge clk);
        check("R10 back idle", cal_mode, 0);
    endtask

    // R11: exit in idle, abandoned adjust, single update
    task automatic test_exit_cases();
        run_adjust(4'b0101, 2, "R11 setup");
        send(3'b000);
        check("R11 idle exit keeps pu", pu_step, exp_pu);
        check("R11 idle exit keeps pd", pd_step, exp_pd);
        @(negedge clk);
        emr_wr = 1'b1; ocd_code = 3'b100; wr_lat = WL_W'(4);
        @(negedge clk);
        emr_wr = 1'b0; ocd_code = 3'b000;
        send(3'b000);
        beats(4'b0101);
        check("R11 abandoned adjust pu", pu_step, exp_pu);
        check("R11 abandoned adjust pd", pd_step, exp_pd);
        check("R11 abandoned mode", cal_mode, 0);
        @(negedge clk);
        emr_wr = 1'b1; ocd_code = 3'b100; wr_lat = WL_W'(1);
        @(negedge clk);
        emr_wr = 1'b0; ocd_code = 3'b000;
        beats(4'b0010);
        model(4'b0010);
        beats(4'b0010);
        beats(4'b0001);
        check("R11 single update pu", pu_step, exp_pu);
        check("R11 single update pd", pd_step, exp_pd);
        send(3'b000);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_drive(1'b1);
        test_drive(1'b0);
        test_codes();
        test_saturate();
        test_default();
        test_errors();
        test_exit_cases();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule